// File: doc/BRIEF.md
# Calendar Counter with Staged Commit

The block keeps wall-clock time as seven binary fields: seconds, minutes, hours, day of month, day of week, month and year. A one-pulse-per-second tick input advances them. The day of month follows the length of each month, and February gains a day in leap years. The year is a 7-bit count of years since 1968, so it spans 128 years. Software reads the live fields over a simple 16-bit register bus.

Software does not write the live fields directly. Bus writes land in a staging copy of all seven fields. Writing 1 to a trigger word starts a transfer, and a busy bit in the status word reads 1 while the transfer runs. When the busy bit clears, the whole staged set has replaced the live set in one step. Because the commit is atomic, a half-written date can never roll over underneath software. If a tick arrives on the same cycle as the commit, the committed values win and that tick is discarded.

The bus carries byte offsets of 16-bit words, and address bit 0 is ignored. Word map:
- Status at 0x00. Bit 6 is the busy bit; all other bits read 0.
- Time fields at 0x0A through 0x16.
- Trigger at 0x3C.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the live fields read seconds 0, minutes 0, hours 0, day of month 1, day of week 0, month 1 and year 0, and the status word at 0x00 reads 0.
- R2: A write to a time word changes only the staging copy. The live value read back stays unchanged until a commit, and the commit loads all seven staged fields together. The field offsets are:
  - 0x0A: seconds
  - 0x0C: minutes
  - 0x0E: hours
  - 0x10: day of month
  - 0x12: day of week
  - 0x14: month
  - 0x16: year
- R3: Writing a word with bit 0 set to offset 0x3C starts a transfer. Bit 6 of the status word (value 0x0040) reads 1 from the cycle after the trigger write for BUSY_CYCLES cycles, with a default of 4. The staged values are live when the bit clears.
- R4: A tick pulse while no commit happens advances seconds by one.
- R5: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R6: Day of week counts 0 to 6 and advances on each day carry. Day of month restarts at 1 after the last day of its month and carries into the month:
  - 30 days for months 4, 6, 9 and 11.
  - 31 days for all other months except February.
  - February has 29 days when the year field is a multiple of 4, and 28 days otherwise.
- R7: Month runs from 1 to 12 and wraps from 12 to 1 with a carry into the year. The year field wraps from 127 to 0.
- R8: When a tick and a commit fall on the same clock edge, the live fields take exactly the staged values and the tick is lost.
- R9: While the busy bit is set, writes to the time words and to the trigger word are ignored.
- R10: A trigger write with bit 0 clear starts no transfer. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| secTick | input | 1 | One-cycle pulse once per second |
| busAddr | input | 8 | Byte offset of the accessed word |
| busWrEn | input | 1 | Write strobe for the word at busAddr |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr, combinational |

## Verification
The bench drives full-date rollovers across minute, hour and day boundaries, then across a 31-day month, a 30-day month, a leap February and a non-leap February. It also wraps December of year 127 back to January of year 0. A wrong month-length table or leap test would land on day 29, 31 or 1 at the wrong boundary, and a missing year wrap would read 128 truncated badly or leave the month at 13.

The bench places a tick exactly on the commit edge. A design that let the tick through would show the committed seconds plus one. It also writes new staged data and a second trigger while busy. A design that accepted either would later commit the wrong seconds or hold busy too long. Finally, it checks that nothing shows before the trigger, catching a design that writes live fields directly.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  parameter int DATA_W = 16;
  parameter int SEC_W = 6;
  parameter int MIN_W = 6;
  parameter int HOUR_W = 5;
  parameter int DOM_W = 5;
  parameter int DOW_W = 3;
  parameter int MON_W = 4;
  parameter int YEAR_W = 7;
  parameter int NUM_FIELDS = 7;
  localparam int IDX_W = $clog2(NUM_FIELDS);

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DOW_W-1:0]  dow;
    logic [DOM_W-1:0]  dom;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } calT;

  // control-to-datapath strobes
  typedef struct packed {
    logic             shadowWe;
    logic [IDX_W-1:0] fieldIdx;
    logic             commit;
  } strobeT;

  localparam calT RESET_CAL = '{year: '0, month: MON_W'(1), dow: '0,
                                dom: DOM_W'(1), hour: '0, min: '0, sec: '0};

  function automatic logic [DOM_W-1:0] daysInMonth(input logic [MON_W-1:0] m,
                                                    input logic [YEAR_W-1:0] y);
    case (m)
      MON_W'(2):  return (y[1:0] == 2'b00) ? DOM_W'(29) : DOM_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): return DOM_W'(30);
      default:    return DOM_W'(31);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] fieldWord(input calT c, input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(0): return DATA_W'(c.sec);
      IDX_W'(1): return DATA_W'(c.min);
      IDX_W'(2): return DATA_W'(c.hour);
      IDX_W'(3): return DATA_W'(c.dom);
      IDX_W'(4): return DATA_W'(c.dow);
      IDX_W'(5): return DATA_W'(c.month);
      IDX_W'(6): return DATA_W'(c.year);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUSY_CYCLES = 4,
  parameter int BUSY_BIT = 6,
  parameter int TIME_BASE = 'h0A,
  parameter int TRIG_ADDR = 'h3C,
  parameter int STAT_ADDR = 'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] liveWord,
  output logic [DATA_W-1:0] busRdData,
  output logic              busy,
  output strobeT            strobes
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam int WA_W = ADDR_W - 1;
  localparam logic [WA_W-1:0] TIME_WORD = WA_W'(TIME_BASE / 2);
  localparam logic [WA_W-1:0] TRIG_WORD = WA_W'(TRIG_ADDR / 2);
  localparam logic [WA_W-1:0] STAT_WORD = WA_W'(STAT_ADDR / 2);

  logic [WA_W-1:0] wordAddr;
  logic [WA_W-1:0] relWord;
  logic            isTime;
  logic            isTrig;
  logic            isStat;
  logic            trigger;
  logic [CNT_W-1:0] busyCnt;
  logic            unusedBits;

  assign wordAddr = busAddr[ADDR_W-1:1];
  assign unusedBits = busAddr[0] ^ (^busWrData[DATA_W-1:1]);
  assign relWord  = wordAddr - TIME_WORD;
  assign isTime   = (wordAddr >= TIME_WORD) && (relWord < WA_W'(NUM_FIELDS));
  assign isTrig   = (wordAddr == TRIG_WORD);
  assign isStat   = (wordAddr == STAT_WORD);

  assign busy    = (busyCnt != '0);
  assign trigger = busWrEn && isTrig && busWrData[0] && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (trigger) begin
      busyCnt <= CNT_W'(BUSY_CYCLES);
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.shadowWe = busWrEn && isTime && !busy;
    strobes.fieldIdx = relWord[IDX_W-1:0];
    strobes.commit   = (busyCnt == CNT_W'(1));
  end

  always_comb begin
    busRdData = '0;
    if (isStat) begin
      busRdData[BUSY_BIT] = busy;
    end else if (isTime) begin
      busRdData = liveWord;
    end
  end
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] liveWord,
  output calT               liveCal
);
  calT shadowCal;
  calT nextCal;
  logic unusedHigh;

  assign unusedHigh = ^wrData[DATA_W-1:YEAR_W];

  // one-second advance with carries through the calendar
  always_comb begin
    nextCal = liveCal;
    if (liveCal.sec >= SEC_W'(59)) begin
      nextCal.sec = '0;
      if (liveCal.min >= MIN_W'(59)) begin
        nextCal.min = '0;
        if (liveCal.hour >= HOUR_W'(23)) begin
          nextCal.hour = '0;
          nextCal.dow = (liveCal.dow >= DOW_W'(6)) ? '0 : liveCal.dow + 1'b1;
          if (liveCal.dom >= daysInMonth(liveCal.month, liveCal.year)) begin
            nextCal.dom = DOM_W'(1);
            if (liveCal.month >= MON_W'(12)) begin
              nextCal.month = MON_W'(1);
              nextCal.year  = liveCal.year + 1'b1;
            end else begin
              nextCal.month = liveCal.month + 1'b1;
            end
          end else begin
            nextCal.dom = liveCal.dom + 1'b1;
          end
        end else begin
          nextCal.hour = liveCal.hour + 1'b1;
        end
      end else begin
        nextCal.min = liveCal.min + 1'b1;
      end
    end else begin
      nextCal.sec = liveCal.sec + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCal <= RESET_CAL;
    end else if (strobes.shadowWe) begin
      case (strobes.fieldIdx)
        IDX_W'(0): shadowCal.sec   <= wrData[SEC_W-1:0];
        IDX_W'(1): shadowCal.min   <= wrData[MIN_W-1:0];
        IDX_W'(2): shadowCal.hour  <= wrData[HOUR_W-1:0];
        IDX_W'(3): shadowCal.dom   <= wrData[DOM_W-1:0];
        IDX_W'(4): shadowCal.dow   <= wrData[DOW_W-1:0];
        IDX_W'(5): shadowCal.month <= wrData[MON_W-1:0];
        IDX_W'(6): shadowCal.year  <= wrData[YEAR_W-1:0];
        default: ;
      endcase
    end
  end

  // commit has priority: a coincident tick is dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveCal <= RESET_CAL;
    end else if (strobes.commit) begin
      liveCal <= shadowCal;
    end else if (secTick) begin
      liveCal <= nextCal;
    end
  end

  assign liveWord = fieldWord(liveCal, strobes.fieldIdx);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);
  strobeT            strobes;
  logic              busyFlag;
  logic [DATA_W-1:0] liveWord;
  calT               liveCal;

  rtc_cal_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .liveWord(liveWord), .busRdData(busRdData),
    .busy(busyFlag), .strobes(strobes)
  );

  rtc_cal_datapath dpath (
    .clk(clk), .rstN(rstN), .secTick(secTick), .strobes(strobes),
    .wrData(busWrData), .liveWord(liveWord), .liveCal(liveCal)
  );
endmodule

// File: rtl/rtc_calendar_check.sv
module rtc_calendar_check
  import rtc_cal_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic secTick,
  input logic busy,
  input logic commitPulse,
  input calT  liveCal
);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 2);
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (!busy) busyRun <= '0;
    else if (busyRun <= RUN_W'(BUSY_CYCLES)) busyRun <= busyRun + 1'b1;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(BUSY_CYCLES)); // R3
  AST_BUSY_ENDS_IN_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(commitPulse)); // R3
  AST_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> busy); // R3
  AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !commitPulse) |=> $stable(liveCal)); // R2
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !commitPulse && liveCal.sec < SEC_W'(59)) |=> (liveCal.sec == $past(liveCal.sec) + 1'b1)); // R4
  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !commitPulse) |=> (liveCal.sec < SEC_W'(60))); // R5
  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !commitPulse) |=> (liveCal.dow < DOW_W'(7))); // R6
endmodule

bind rtc_calendar rtc_calendar_check #(.BUSY_CYCLES(BUSY_CYCLES)) chk (
  .clk(clk), .rstN(rstN), .secTick(secTick), .busy(busyFlag),
  .commitPulse(strobes.commit), .liveCal(liveCal)
);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  localparam int BUSY_CYCLES = 4;

  logic        clk = 0;
  logic        rstN = 0;
  logic        secTick = 0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [15:0] exp;
    string       req;
  } itemT;
  itemT sb[$];

  rtc_calendar #(.ADDR_W(8), .BUSY_CYCLES(BUSY_CYCLES)) uut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData)
  );

  always #5 clk = ~clk;

  // monitor: compares the read data against the queued expectation
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      itemT it;
      it = sb.pop_front();
      checks++;
      if (busRdData !== it.exp) begin
        errors++;
        $display("FAIL %s addr=0x%02h actual=0x%04h expected=0x%04h",
                 it.req, it.addr, busRdData, it.exp);
      end
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1;
    @(posedge clk); #1;
    busWrEn = 0;
  endtask

  task automatic expectRd(input logic [7:0] a, input logic [15:0] e, input string req);
    itemT it;
    busAddr = a;
    it.addr = a; it.exp = e; it.req = req;
    sb.push_back(it);
    @(negedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic pulseTick();
    @(posedge clk); #1; secTick = 1;
    @(posedge clk); #1; secTick = 0;
  endtask

  task automatic commitWait();
    busWrite(8'h3C, 16'h0001);
    repeat (BUSY_CYCLES + 1) @(posedge clk);
    #1;
  endtask

  task automatic stageAll(input int s, input int mi, input int h, input int d,
                          input int w, input int mo, input int y);
    busWrite(8'h0A, 16'(s));  busWrite(8'h0C, 16'(mi));
    busWrite(8'h0E, 16'(h));  busWrite(8'h10, 16'(d));
    busWrite(8'h12, 16'(w));  busWrite(8'h14, 16'(mo));
    busWrite(8'h16, 16'(y));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;

    // R1 reset state
    expectRd(8'h00, 16'h0000, "R1 status");
    expectRd(8'h0A, 16'd0, "R1 sec");
    expectRd(8'h10, 16'd1, "R1 dom");
    expectRd(8'h12, 16'd0, "R1 dow");
    expectRd(8'h14, 16'd1, "R1 month");
    expectRd(8'h16, 16'd0, "R1 year");
    expectRd(8'h20, 16'd0, "R10 unmapped");

    // R2 staged writes invisible until commit
    busWrite(8'h0A, 16'd30);
    busWrite(8'h0C, 16'd15);
    expectRd(8'h0A, 16'd0, "R2 sec before commit");
    busWrite(8'h3C, 16'h0001);
    expectRd(8'h00, 16'h0040, "R3 busy set");
    repeat (BUSY_CYCLES) @(posedge clk);
    #1;
    expectRd(8'h00, 16'h0000, "R3 busy cleared");
    expectRd(8'h0A, 16'd30, "R2 sec committed");
    expectRd(8'h0C, 16'd15, "R2 min committed");

    // R4 tick
    pulseTick();
    expectRd(8'h0A, 16'd31, "R4 sec step");

    // R5 carry into hour only
    stageAll(59, 59, 5, 10, 1, 3, 2); commitWait(); pulseTick();
    expectRd(8'h0A, 16'd0, "R5 sec wrap");
    expectRd(8'h0C, 16'd0, "R5 min wrap");
    expectRd(8'h0E, 16'd6, "R5 hour step");
    expectRd(8'h10, 16'd10, "R5 dom unchanged");

    // R6 31-day month end, dow wrap
    stageAll(59, 59, 23, 31, 6, 1, 0); commitWait(); pulseTick();
    expectRd(8'h0E, 16'd0, "R5 hour wrap");
    expectRd(8'h10, 16'd1, "R6 dom after Jan31");
    expectRd(8'h12, 16'd0, "R6 dow wrap");
    expectRd(8'h14, 16'd2, "R6 month after Jan");

    // R6 leap February
    stageAll(59, 59, 23, 28, 2, 2, 0); commitWait(); pulseTick();
    expectRd(8'h10, 16'd29, "R6 leap Feb29");
    expectRd(8'h14, 16'd2, "R6 leap still Feb");
    expectRd(8'h12, 16'd3, "R6 dow step");

    // R6 non-leap February
    stageAll(59, 59, 23, 28, 2, 2, 1); commitWait(); pulseTick();
    expectRd(8'h10, 16'd1, "R6 nonleap Mar1");
    expectRd(8'h14, 16'd3, "R6 nonleap month");

    // R6 30-day month
    stageAll(59, 59, 23, 30, 3, 4, 5); commitWait(); pulseTick();
    expectRd(8'h10, 16'd1, "R6 Apr30 wrap");
    expectRd(8'h14, 16'd5, "R6 May");

    // R7 year wrap
    stageAll(59, 59, 23, 31, 4, 12, 127); commitWait(); pulseTick();
    expectRd(8'h14, 16'd1, "R7 month wrap");
    expectRd(8'h16, 16'd0, "R7 year wrap");
    expectRd(8'h12, 16'd5, "R7 dow");

    // R8 tick on the commit edge is dropped
    stageAll(10, 0, 0, 1, 0, 1, 0);
    busWrite(8'h3C, 16'h0001);
    repeat (BUSY_CYCLES - 1) @(posedge clk);
    #1 secTick = 1;
    @(posedge clk); #1 secTick = 0;
    expectRd(8'h00, 16'h0000, "R8 busy done");
    expectRd(8'h0A, 16'd10, "R8 tick dropped");

    // R9 writes while busy ignored
    busWrite(8'h3C, 16'h0001);
    busWrite(8'h0A, 16'd50);
    busWrite(8'h3C, 16'h0001);
    repeat (BUSY_CYCLES) @(posedge clk);
    #1;
    expectRd(8'h00, 16'h0000, "R9 busy not extended");
    commitWait();
    expectRd(8'h0A, 16'd10, "R9 staged sec kept");

    // R10 trigger with bit 0 clear
    busWrite(8'h3C, 16'h0002);
    expectRd(8'h00, 16'h0000, "R10 no transfer");

    @(posedge clk); #1;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule